// File: doc/BRIEF.md
# BCD Time and Calendar Counter Chain

This block keeps wall-clock time and date as a chain of binary-coded-decimal digit counters. A one-cycle enable pulse, normally once per second, advances the chain. Seconds, minutes, hours, weekday, day of month, month and a two-digit year all sit in this chain. Carries ripple through it in the same cycle as the pulse. Hours run in either a 24-hour or a 12-hour format with a morning/afternoon flag. February length follows a programmable leap-year phase.

A host sees thirteen 4-bit digit registers selected by an index. It reads them through a combinational read port and loads any one of them per cycle through a synchronous load strobe. A hold input freezes timekeeping while the host sets a consistent time. A pulse that arrives during a load is held back one cycle and then applied, unless the load targets a seconds digit, which discards it.

Top module: `rtc_calendar_chain`

## Requirements
- R1: Digit indices map as 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens. A load at an index is read back at the same index with unused high bits reading 0.
- R2: Seconds and minutes count 00 to 59. Units wrap after 9 and carry into tens. Tens wrap after 5 and carry into the next field.
- R3: When hours-tens bit 3 is 1, hours count 00 to 23. The 23 to 00 step advances the day.
- R4: When hours-tens bit 3 is 0, hours run 12, 01 … 11. Hours-tens bit 2 is the afternoon flag and toggles on the 11 to 12 step. The 11 PM to 12 AM step advances the day.
- R5: Loading hours-tens with bit 3 = 1 leaves bit 2 reading 0, whatever was written. A load with bit 3 = 0 keeps the written bit 2.
- R6: Each day advance steps the weekday 0 to 6, with 6 wrapping to 0.
- R7: Day counts from 01 to the month length: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. A month end sets the day to 01 and advances the month. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: Day-tens bits 3:2 (00, 01, 10, 11) pick the year/4 remainder (0, 3, 2, 1) that marks a leap year. February has 29 days when (2·yearTens + yearUnits) mod 4 equals that remainder, and 28 otherwise. The bits survive day counting.
- R9: A load takes priority over a tick in the same cycle. A tick that coincides with a load of any non-seconds digit is applied in the next cycle.
- R10: A tick that coincides with a load of a seconds digit (index 0 or 1) is discarded.
- R11: While the hold input is high, ticks have no effect on any digit.
- R12: Reset sets 00:00:00 in 24-hour mode, weekday 0, day 01, month 01, year 00 and leap selector 00. Hours-tens therefore reads 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle advance pulse (1 Hz) |
| holdCarry | input | 1 | Freezes counting while high |
| loadEn | input | 1 | Load strobe for one digit register |
| loadIdx | input | 4 | Index of the register to load |
| loadData | input | 4 | Value to load |
| rdIdx | input | 4 | Index of the register to read |
| rdData | output | 4 | Selected register contents |

## Verification
On every cycle the assertions check several things: the 59 to 00 seconds wrap, the 23 to 00 wrap in 24-hour mode, the afternoon flag cleared by a 24-hour load, weekday wrap on a day advance, month reset on a year advance and the deferral of a tick that collides with a load. Month lengths, the four leap phases, the twelve-hour sequence and the flag toggle only become visible in the bench's scenarios. The same holds for dropped ticks on seconds loads and hold behaviour. Each scenario loads a full date and time, applies a tick and compares all thirteen registers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 13;
  localparam int IDX_W      = $clog2(NUM_DIGITS);

  localparam logic [IDX_W-1:0] IDX_SEC_U = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SEC_T = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_MIN_U = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_MIN_T = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_HR_U  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_HR_T  = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_WDAY  = IDX_W'(6);
  localparam logic [IDX_W-1:0] IDX_DAY_U = IDX_W'(7);
  localparam logic [IDX_W-1:0] IDX_DAY_T = IDX_W'(8);
  localparam logic [IDX_W-1:0] IDX_MON_U = IDX_W'(9);
  localparam logic [IDX_W-1:0] IDX_MON_T = IDX_W'(10);
  localparam logic [IDX_W-1:0] IDX_YR_U  = IDX_W'(11);
  localparam logic [IDX_W-1:0] IDX_YR_T  = IDX_W'(12);

  typedef struct packed {
    logic               step;
    logic               load;
    logic [IDX_W-1:0]   idx;
    logic [DIGIT_W-1:0] data;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic               monT,
  input  logic [DIGIT_W-1:0] monU,
  input  logic [DIGIT_W-1:0] yrT,
  input  logic [DIGIT_W-1:0] yrU,
  input  logic [1:0]         leapSel,
  output logic [1:0]         lastT,
  output logic [DIGIT_W-1:0] lastU
);
  logic [1:0] yearResidue;
  logic       isLeap;
  logic       isFeb;
  logic       isShort;

  // (2*tens + units) mod 4 only needs tens bit 0 and units bits 1:0
  assign yearResidue = yrU[1:0] + {yrT[0], 1'b0};
  // selector 00/01/10/11 -> remainder 0/3/2/1, i.e. residue + sel == 0 mod 4
  assign isLeap = ((yearResidue + leapSel) == 2'd0);
  assign isFeb  = !monT && (monU == 4'd2);
  assign isShort = (!monT && (monU == 4'd4 || monU == 4'd6 || monU == 4'd9)) ||
                   (monT && monU == 4'd1);

  always_comb begin
    if (isFeb) begin
      lastT = 2'd2;
      lastU = isLeap ? 4'd9 : 4'd8;
    end else if (isShort) begin
      lastT = 2'd3;
      lastU = 4'd0;
    end else begin
      lastT = 2'd3;
      lastU = 4'd1;
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               holdCarry,
  input  logic               loadEn,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [DIGIT_W-1:0] loadData,
  output rtcStrobe_t         strb
);
  logic pendingTick;
  logic tickWanted;
  logic isSecIdx;

  assign tickWanted = tickEn | pendingTick;
  assign isSecIdx   = (loadIdx == IDX_SEC_U) || (loadIdx == IDX_SEC_T);

  always_comb begin
    strb.step = tickWanted & ~holdCarry & ~loadEn;
    strb.load = loadEn;
    strb.idx  = loadIdx;
    strb.data = loadData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingTick <= 1'b0;
    else       pendingTick <= loadEn & tickWanted & ~holdCarry & ~isSecIdx;
  end

  // R9: a tick colliding with a non-seconds load steps on the next free cycle
  assert_defer_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && tickEn && !holdCarry && !isSecIdx) |=> (loadEn || holdCarry || strb.step));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rtcStrobe_t         strb,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DIGIT_W-1:0] rdData
);
  logic [3:0] secU, minU, hrU, dayU, monU, yrU, yrT;
  logic [2:0] secT, minT, wday;
  logic [1:0] hrT, dayT, leapSel;
  logic       monT, mode24, pm;

  logic [3:0] secUN, minUN, hrUN, dayUN, monUN, yrUN, yrTN;
  logic [2:0] secTN, minTN, wdayN;
  logic [1:0] hrTN, dayTN;
  logic       monTN, pmN;

  logic       cSecT, cMinU, cMinT, cHour, dayAdv, monAdv, yrAdv, yrTAdv;
  logic       hourWrap, dayAtEnd, monWrap;
  logic [1:0] lastT;
  logic [3:0] lastU;

  rtc_month_len u_monLen (
    .monT(monT), .monU(monU), .yrT(yrT), .yrU(yrU), .leapSel(leapSel),
    .lastT(lastT), .lastU(lastU)
  );

  assign cSecT  = strb.step && (secU >= 4'd9);
  assign cMinU  = cSecT && (secT >= 3'd5);
  assign cMinT  = cMinU && (minU >= 4'd9);
  assign cHour  = cMinT && (minT >= 3'd5);
  assign dayAdv = cHour && hourWrap;
  assign dayAtEnd = (dayT > lastT) || ((dayT == lastT) && (dayU >= lastU));
  assign monAdv = dayAdv && dayAtEnd;
  assign monWrap = monT && (monU >= 4'd2);
  assign yrAdv  = monAdv && monWrap;
  assign yrTAdv = yrAdv && (yrU >= 4'd9);

  // hour step: next value and whether it rolls into a new day
  always_comb begin
    hrUN = hrU;
    hrTN = hrT;
    pmN  = pm;
    hourWrap = 1'b0;
    if (mode24) begin
      if (hrT >= 2'd2 && hrU >= 4'd3) begin
        hrTN = 2'd0; hrUN = 4'd0; hourWrap = 1'b1;
      end else if (hrU >= 4'd9) begin
        hrTN = hrT + 2'd1; hrUN = 4'd0;
      end else begin
        hrUN = hrU + 4'd1;
      end
    end else begin
      if (hrT != 2'd0 && hrU >= 4'd2) begin
        hrTN = 2'd0; hrUN = 4'd1;
      end else if (hrT != 2'd0 && hrU == 4'd1) begin
        hrTN = 2'd1; hrUN = 4'd2; pmN = ~pm; hourWrap = pm;
      end else if (hrU >= 4'd9) begin
        hrTN = 2'd1; hrUN = 4'd0;
      end else begin
        hrUN = hrU + 4'd1;
      end
    end
  end

  always_comb begin
    secUN = (secU >= 4'd9) ? 4'd0 : secU + 4'd1;
    secTN = (secT >= 3'd5) ? 3'd0 : secT + 3'd1;
    minUN = (minU >= 4'd9) ? 4'd0 : minU + 4'd1;
    minTN = (minT >= 3'd5) ? 3'd0 : minT + 3'd1;
    wdayN = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
    if (dayAtEnd) begin
      dayTN = 2'd0; dayUN = 4'd1;
    end else if (dayU >= 4'd9) begin
      dayTN = dayT + 2'd1; dayUN = 4'd0;
    end else begin
      dayTN = dayT; dayUN = dayU + 4'd1;
    end
    if (monWrap) begin
      monTN = 1'b0; monUN = 4'd1;
    end else if (monU >= 4'd9) begin
      monTN = 1'b1; monUN = 4'd0;
    end else begin
      monTN = monT; monUN = monU + 4'd1;
    end
    yrUN = (yrU >= 4'd9) ? 4'd0 : yrU + 4'd1;
    yrTN = (yrT >= 4'd9) ? 4'd0 : yrT + 4'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secU <= '0; secT <= '0; minU <= '0; minT <= '0;
      hrU <= '0; hrT <= '0; mode24 <= 1'b1; pm <= 1'b0;
      wday <= '0; dayU <= 4'd1; dayT <= '0; leapSel <= '0;
      monU <= 4'd1; monT <= 1'b0; yrU <= '0; yrT <= '0;
    end else if (strb.load) begin
      case (strb.idx)
        IDX_SEC_U: secU <= strb.data;
        IDX_SEC_T: secT <= strb.data[2:0];
        IDX_MIN_U: minU <= strb.data;
        IDX_MIN_T: minT <= strb.data[2:0];
        IDX_HR_U:  hrU  <= strb.data;
        IDX_HR_T: begin
          hrT    <= strb.data[1:0];
          mode24 <= strb.data[3];
          pm     <= strb.data[2] & ~strb.data[3];
        end
        IDX_WDAY:  wday <= strb.data[2:0];
        IDX_DAY_U: dayU <= strb.data;
        IDX_DAY_T: begin
          dayT    <= strb.data[1:0];
          leapSel <= strb.data[3:2];
        end
        IDX_MON_U: monU <= strb.data;
        IDX_MON_T: monT <= strb.data[0];
        IDX_YR_U:  yrU  <= strb.data;
        IDX_YR_T:  yrT  <= strb.data;
        default: ;
      endcase
    end else begin
      if (strb.step) secU <= secUN;
      if (cSecT)     secT <= secTN;
      if (cMinU)     minU <= minUN;
      if (cMinT)     minT <= minTN;
      if (cHour) begin
        hrU <= hrUN; hrT <= hrTN; pm <= pmN;
      end
      if (dayAdv) begin
        wday <= wdayN; dayU <= dayUN; dayT <= dayTN;
      end
      if (monAdv) begin
        monU <= monUN; monT <= monTN;
      end
      if (yrAdv)  yrU <= yrUN;
      if (yrTAdv) yrT <= yrTN;
    end
  end

  always_comb begin
    case (rdIdx)
      IDX_SEC_U: rdData = secU;
      IDX_SEC_T: rdData = {1'b0, secT};
      IDX_MIN_U: rdData = minU;
      IDX_MIN_T: rdData = {1'b0, minT};
      IDX_HR_U:  rdData = hrU;
      IDX_HR_T:  rdData = {mode24, pm, hrT};
      IDX_WDAY:  rdData = {1'b0, wday};
      IDX_DAY_U: rdData = dayU;
      IDX_DAY_T: rdData = {leapSel, dayT};
      IDX_MON_U: rdData = monU;
      IDX_MON_T: rdData = {3'b000, monT};
      IDX_YR_U:  rdData = yrU;
      IDX_YR_T:  rdData = yrT;
      default:   rdData = '0;
    endcase
  end

  // R2: a step at xx:59 seconds lands on :00
  assert_sec_rollover_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && secU == 4'd9 && secT == 3'd5) |=> (secU == 4'd0 && secT == 3'd0));

  // R3: 23:59:59 in 24-hour mode rolls to hour 00
  assert_hr24_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cHour && mode24 && hrT == 2'd2 && hrU == 4'd3) |=> (hrT == 2'd0 && hrU == 4'd0));

  // R5: a 24-hour load never leaves the afternoon flag set
  assert_pm_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.idx == IDX_HR_T && strb.data[3]) |=> (mode24 && !pm));

  // R6: weekday 6 wraps to 0 on a day advance
  assert_wday_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dayAdv && wday == 3'd6) |=> (wday == 3'd0));

  // R7: a year advance restarts the month at 01
  assert_month_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    yrAdv |=> (!monT && monU == 4'd1));
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               holdCarry,
  input  logic               loadEn,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [DIGIT_W-1:0] loadData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DIGIT_W-1:0] rdData
);
  rtcStrobe_t strb;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdCarry(holdCarry),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData), .strb(strb)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: tb/rtc_calendar_chain_tb.sv
`timescale 1ns/1ps
module rtc_calendar_chain_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       holdCarry = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] loadIdx = '0;
  logic [3:0] loadData = '0;
  logic [3:0] rdIdx = '0;
  logic [3:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_chain u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdCarry(holdCarry),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  // digit i at bits 4i+3:4i, written year tens first
  localparam int NV = 23;
  localparam int TAG [NV] = '{2,2,2,3,3,4,4,4,4,7,7,7,7,7,7,7,8,8,8,8,8,8,8};
  localparam logic [51:0] PRE [NV] = '{
    52'h2503152900009, // R2 seconds units carry
    52'h2503152900959, // R2 minute units carry
    52'h2503152905959, // R2 hour carry
    52'h2503152995959, // R3 19 -> 20
    52'h2503156A35959, // R3 23 -> 00, R6 weekday 6 -> 0
    52'h2503152095959, // R4 09 -> 10 AM
    52'h2503152115959, // R4 11 AM -> 12 PM
    52'h2503152525959, // R4 12 PM -> 01 PM
    52'h2503152515959, // R4 11 PM -> 12 AM next day
    52'h2501304A35959, // R7 Jan 30 -> 31
    52'h2501314A35959, // R7 Jan 31 -> Feb 01
    52'h2504304A35959, // R7 Apr 30 -> May 01
    52'h2509303A35959, // R7 Sep 30 -> Oct 01
    52'h2511303A35959, // R7 Nov 30 -> Dec 01
    52'h1912313A35959, // R7 year units carry into tens
    52'h9912316A35959, // R7 year 99 -> 00
    52'h2402281A35959, // R8 sel 00, year 24 leap
    52'h2502281A35959, // R8 sel 00, year 25 common
    52'h2402291A35959, // R8 Feb 29 -> Mar 01
    52'h2302681A35959, // R8 sel 01, year 23 leap
    52'h2402681A35959, // R8 sel 01, year 24 common
    52'h2102E81A35959, // R8 sel 11, year 21 leap
    52'h2202A81A35959  // R8 sel 10, year 22 leap
  };
  localparam logic [51:0] POST [NV] = '{
    52'h2503152900010, 52'h2503152901000, 52'h2503152910000,
    52'h2503152A00000, 52'h2503160800000,
    52'h2503152100000, 52'h2503152520000, 52'h2503152410000,
    52'h2503163120000,
    52'h2501315800000, 52'h2502015800000, 52'h2505015800000,
    52'h2510014800000, 52'h2512014800000, 52'h2001014800000,
    52'h0001010800000,
    52'h2402292800000, 52'h2503012800000, 52'h2403012800000,
    52'h2302692800000, 52'h2403412800000, 52'h2102E92800000,
    52'h2202A92800000
  };

  task automatic readAll(output logic [51:0] v);
    v = '0;
    for (int i = 0; i < 13; i++) begin
      rdIdx = 4'(i);
      #0.1;
      v[4*i +: 4] = rdData;
    end
  endtask

  task automatic readOne(input logic [3:0] idx, output logic [3:0] d);
    rdIdx = idx;
    #0.1;
    d = rdData;
  endtask

  task automatic loadAll(input logic [51:0] v);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadIdx = 4'(i); loadData = v[4*i +: 4];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic tickOnce();
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic check52(input string req, input logic [51:0] got, input logic [51:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check4(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish();
  end

  initial begin
    logic [51:0] v;
    logic [3:0]  d;
    repeat (3) @(negedge clk);
    // R12 / R1: reset contents at every index
    readAll(v);
    check52("R12 reset state", v, 52'h0001010800000);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: load a full time, one tick, compare every register
    for (int k = 0; k < NV; k++) begin
      loadAll(PRE[k]);
      readAll(v);
      check52("R1 load readback", v, PRE[k]);
      tickOnce();
      readAll(v);
      total++;
      if (v !== POST[k]) begin
        bad++;
        $display("FAIL R%0d vec %0d got=%h exp=%h", TAG[k], k, v, POST[k]);
      end
    end

    // R5: 24-hour load clears the afternoon bit, 12-hour load keeps it
    @(negedge clk); loadEn = 1'b1; loadIdx = 4'd5; loadData = 4'hE;
    @(negedge clk); loadEn = 1'b0;
    readOne(4'd5, d); check4("R5 hour tens 24h load", d, 4'hA);
    @(negedge clk); loadEn = 1'b1; loadIdx = 4'd5; loadData = 4'h5;
    @(negedge clk); loadEn = 1'b0;
    readOne(4'd5, d); check4("R5 hour tens 12h load", d, 4'h5);

    // R1: unused high bits read 0 (month tens keeps bit 0 only)
    @(negedge clk); loadEn = 1'b1; loadIdx = 4'd10; loadData = 4'hF;
    @(negedge clk); loadEn = 1'b0;
    readOne(4'd10, d); check4("R1 month tens width", d, 4'h1);

    loadAll(52'h2503152900000);
    // R9: tick during a minutes load is deferred one cycle
    @(negedge clk);
    tickEn = 1'b1; loadEn = 1'b1; loadIdx = 4'd2; loadData = 4'd7;
    @(negedge clk);
    tickEn = 1'b0; loadEn = 1'b0;
    readOne(4'd0, d); check4("R9 no step in load cycle", d, 4'd0);
    readOne(4'd2, d); check4("R9 load wins", d, 4'd7);
    @(negedge clk);
    readOne(4'd0, d); check4("R9 deferred step", d, 4'd1);

    // R10: tick during a seconds load is dropped
    @(negedge clk);
    tickEn = 1'b1; loadEn = 1'b1; loadIdx = 4'd0; loadData = 4'd5;
    @(negedge clk);
    tickEn = 1'b0; loadEn = 1'b0;
    readOne(4'd0, d); check4("R10 seconds loaded", d, 4'd5);
    @(negedge clk);
    readOne(4'd0, d); check4("R10 tick dropped", d, 4'd5);
    readOne(4'd2, d); check4("R10 minutes untouched", d, 4'd7);

    // R11: ticks while holding change nothing
    loadAll(52'h2503156A35959);
    @(negedge clk);
    holdCarry = 1'b1;
    for (int t = 0; t < 3; t++) tickOnce();
    readAll(v);
    check52("R11 frozen under hold", v, 52'h2503156A35959);
    holdCarry = 1'b0;
    @(negedge clk);
    readAll(v);
    check52("R11 no late step after hold", v, 52'h2503156A35959);
    tickOnce();
    readAll(v);
    check52("R11 counting resumes", v, 52'h2503160800000);

    finish();
  end
endmodule